// File: doc/BRIEF.md
# Dual-Bus Flash Command Snooper

This block sits in the transmit path of a serial flash controller that drives two flash devices side by side. Each device has its own bus. When chip select goes active, the block reads the first byte taken from the transmit FIFO as a flash opcode. From that opcode it works out how many address and dummy bytes follow. While those header bytes go out, both buses carry the same byte. The FIFOs see only one pop and one push per exchange, and bus 0's response is the one kept.

Once the header is done, the block switches to interleaving. Each exchange then pops two bytes, one for each bus. The two responses are pushed back in bus order, bus 0 first. An opcode that is not recognised keeps the block in single-byte mode until chip select is released. Interleaving happens only when dual mode is enabled. With dual mode off, the block still tracks the opcode, but every exchange moves one byte.

The surrounding controller works as follows:

- It presents the head bytes of the TX FIFO and a saturated count of the bytes available.
- It raises `xfer_step` for each exchange slot.
- It applies the pop and push counts the block returns, in the same cycle.

Top module: `dual_flash_snoop`

## Requirements
- R1: After reset, `snoop_mode` is 0 (waiting for an opcode) and `snoop_count` is 0, before any exchange.
- R2: An accepted exchange in mode 0 whose byte is 0x03, 0x02, 0xA2 or 0x32 moves the block to mode 2 (header countdown) with a count of 3.
- R3: An accepted exchange in mode 0 whose byte is 0x0B, 0x3B, 0x6B or 0xBB moves the block to mode 2 with a count of 4.
- R4: An accepted exchange in mode 0 whose byte is 0xEB moves the block to mode 2 with a count of 6.
- R5: Any other byte in mode 0 moves the block to mode 1 (no interleaving). It stays in mode 1, with count 0, for every later exchange while chip select stays active.
- R6: In mode 2, each accepted exchange lowers the count by one. The exchange that takes the count from 1 to 0 moves the block to mode 3 (interleaving).
- R7: An accepted exchange outside mode 3 has the following effects:
  - The TX FIFO pops one byte and the RX FIFO pushes one byte.
  - Both `bus0_tx` and `bus1_tx` equal `tx_head0`.
  - `rx_byte0` equals `bus0_rx`.
- R8: An accepted exchange in mode 3 with `dual_en` high has the following effects:
  - The TX FIFO pops two bytes and the RX FIFO pushes two bytes.
  - `bus0_tx` is `tx_head0` and `bus1_tx` is `tx_head1`.
  - `rx_byte0` is `bus0_rx` and `rx_byte1` is `bus1_rx`.
- R9: With `dual_en` low, the opcode tracking still runs. An exchange in mode 3 pops one byte, pushes one byte and drives `tx_head0` on both buses.
- R10: An exchange is short of data when `tx_avail` is below the bytes it needs (2 in interleaving with dual mode, otherwise 1). A short exchange has the following effects:
  - `underflow` is 1 in that cycle.
  - Both pop and push counts are 0.
  - Mode and count are unchanged.
- R11: While `cs_active` is low, `xfer_step` is ignored: pop and push are 0. Mode and count return to 0 at the next clock edge.
- R12: While `cs_active` is high and `xfer_step` is low, pop and push are 0, `underflow` is 0, and mode and count hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_active | input | 1 | At least one chip select is asserted |
| dual_en | input | 1 | Two memories on separate buses; enables interleaving |
| xfer_step | input | 1 | Request one byte exchange this cycle |
| tx_avail | input | 2 | Bytes in the TX FIFO, saturated at 3 |
| tx_head0 | input | 8 | Oldest TX FIFO byte |
| tx_head1 | input | 8 | Second-oldest TX FIFO byte |
| bus0_rx | input | 8 | Byte returned by bus 0 |
| bus1_rx | input | 8 | Byte returned by bus 1 |
| bus0_tx | output | 8 | Byte sent on bus 0 |
| bus1_tx | output | 8 | Byte sent on bus 1 |
| tx_pop | output | 2 | Number of TX FIFO bytes consumed this cycle |
| rx_push | output | 2 | Number of RX FIFO bytes written this cycle |
| rx_byte0 | output | 8 | First byte to write into the RX FIFO |
| rx_byte1 | output | 8 | Second byte to write into the RX FIFO |
| underflow | output | 1 | Exchange abandoned for lack of TX data |
| snoop_mode | output | 2 | 0 waiting, 1 no interleave, 2 header countdown, 3 interleaving |
| snoop_count | output | 3 | Header bytes still to send in mode 2 |

## Verification
The bench decodes all 256 opcode values and follows each one through its full header, checking the pop and push pattern on every byte. It then checks two interleaved exchanges after the header. This catches three kinds of error:

- A wrong class table, which lands on the wrong count.
- An off-by-one in the countdown, which interleaves one byte early or late and scrambles the address on the second memory.
- An unknown opcode that drifts into interleaving.

Underflow is tested both on the opcode byte and on an interleaved exchange that has only one byte available. A design that popped anyway or advanced its state would desynchronise the FIFOs. Dropping chip select mid-header, and running with dual mode off, check that the block neither keeps stale header state nor splits data across a single bus.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

  typedef enum logic [1:0] {
    SN_WAIT   = 2'd0,
    SN_PLAIN  = 2'd1,
    SN_HEADER = 2'd2,
    SN_STRIPE = 2'd3
  } snoop_mode_e;

  // Header bytes that follow an opcode; 0 means the opcode is not known.
  function automatic logic [2:0] header_len(input logic [7:0] op);
    logic [2:0] n;
    case (op)
      8'h03, 8'h02, 8'hA2, 8'h32: n = 3'd3;
      8'h0B, 8'h3B, 8'h6B, 8'hBB: n = 3'd4;
      8'hEB:                      n = 3'd6;
      default:                    n = 3'd0;
    endcase
    return n;
  endfunction

  // Bytes one exchange consumes from the TX FIFO.
  function automatic logic [1:0] bytes_per_xchg(input snoop_mode_e m,
                                                input logic dual);
    return (dual && (m == SN_STRIPE)) ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/dfs_decode.sv
module dfs_decode #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic [BYTE_W-1:0] opcode,
  output logic [CNT_W-1:0]  hdr_len,
  output logic              known
);
  import dfs_pkg::*;

  logic [2:0] raw_len;

  always_comb begin
    raw_len = header_len(opcode[7:0]);
    hdr_len = CNT_W'(raw_len);
    known   = (raw_len != 3'd0);
  end

endmodule

// File: rtl/dfs_state.sv
module dfs_state #(
  parameter int CNT_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_active,
  input  logic                 accept,
  input  logic                 op_known,
  input  logic [CNT_W-1:0]     op_len,
  output dfs_pkg::snoop_mode_e mode_q,
  output logic [CNT_W-1:0]     count_q
);
  import dfs_pkg::*;

  snoop_mode_e      mode_d;
  logic [CNT_W-1:0] count_d;
  logic             header_done;

  assign header_done = (count_q == CNT_W'(1));

  always_comb begin
    mode_d  = mode_q;
    count_d = count_q;
    if (!cs_active) begin
      mode_d  = SN_WAIT;
      count_d = '0;
    end else if (accept) begin
      case (mode_q)
        SN_WAIT: begin
          if (op_known) begin
            mode_d  = SN_HEADER;
            count_d = op_len;
          end else begin
            mode_d  = SN_PLAIN;
          end
        end
        SN_HEADER: begin
          count_d = count_q - CNT_W'(1);
          if (header_done) mode_d = SN_STRIPE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= SN_WAIT;
      count_q <= '0;
    end else begin
      mode_q  <= mode_d;
      count_q <= count_d;
    end
  end

  // R6
  header_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == SN_HEADER) |-> (count_q != '0));

  // R11
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> (mode_q == SN_WAIT) && (count_q == '0));

  // R5
  plain_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == SN_PLAIN) && cs_active |=> (mode_q == SN_PLAIN));

endmodule

// File: rtl/dfs_lane.sv
module dfs_lane #(
  parameter int BYTE_W = 8,
  parameter int LANE   = 0
) (
  input  logic              split,
  input  logic [BYTE_W-1:0] head_shared,
  input  logic [BYTE_W-1:0] head_own,
  input  logic [BYTE_W-1:0] rx_in,
  output logic [BYTE_W-1:0] tx_out,
  output logic [BYTE_W-1:0] rx_keep
);
  generate
    if (LANE == 0) begin : g_lead
      assign tx_out  = head_shared;
      assign rx_keep = rx_in;
    end else begin : g_follow
      assign tx_out  = split ? head_own : head_shared;
      assign rx_keep = split ? rx_in : '0;
    end
  endgenerate
endmodule

// File: rtl/dual_flash_snoop.sv
module dual_flash_snoop #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              dual_en,
  input  logic              xfer_step,
  input  logic [1:0]        tx_avail,
  input  logic [BYTE_W-1:0] tx_head0,
  input  logic [BYTE_W-1:0] tx_head1,
  input  logic [BYTE_W-1:0] bus0_rx,
  input  logic [BYTE_W-1:0] bus1_rx,
  output logic [BYTE_W-1:0] bus0_tx,
  output logic [BYTE_W-1:0] bus1_tx,
  output logic [1:0]        tx_pop,
  output logic [1:0]        rx_push,
  output logic [BYTE_W-1:0] rx_byte0,
  output logic [BYTE_W-1:0] rx_byte1,
  output logic              underflow,
  output logic [1:0]        snoop_mode,
  output logic [CNT_W-1:0]  snoop_count
);
  import dfs_pkg::*;

  localparam int NUM_LANES = 2;

  snoop_mode_e      mode_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] op_len;
  logic             op_known;
  logic [1:0]       need;
  logic             want, short_data, accept, split;

  logic [BYTE_W-1:0] lane_head [NUM_LANES];
  logic [BYTE_W-1:0] lane_rx   [NUM_LANES];
  logic [BYTE_W-1:0] lane_tx   [NUM_LANES];
  logic [BYTE_W-1:0] lane_keep [NUM_LANES];

  assign need       = bytes_per_xchg(mode_q, dual_en);
  assign want       = xfer_step && cs_active;
  assign short_data = want && (tx_avail < need);
  assign accept     = want && !short_data;
  assign split      = dual_en && (mode_q == SN_STRIPE);

  dfs_decode #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_decode (
    .opcode (tx_head0),
    .hdr_len(op_len),
    .known  (op_known)
  );

  dfs_state #(.CNT_W(CNT_W)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_active(cs_active),
    .accept   (accept),
    .op_known (op_known),
    .op_len   (op_len),
    .mode_q   (mode_q),
    .count_q  (count_q)
  );

  assign lane_head[0] = tx_head0;
  assign lane_head[1] = tx_head1;
  assign lane_rx[0]   = bus0_rx;
  assign lane_rx[1]   = bus1_rx;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    dfs_lane #(.BYTE_W(BYTE_W), .LANE(g)) u_lane (
      .split      (split),
      .head_shared(tx_head0),
      .head_own   (lane_head[g]),
      .rx_in      (lane_rx[g]),
      .tx_out     (lane_tx[g]),
      .rx_keep    (lane_keep[g])
    );
  end

  assign bus0_tx     = lane_tx[0];
  assign bus1_tx     = lane_tx[1];
  assign rx_byte0    = lane_keep[0];
  assign rx_byte1    = lane_keep[1];
  assign tx_pop      = accept ? need : 2'd0;
  assign rx_push     = accept ? need : 2'd0;
  assign underflow   = short_data;
  assign snoop_mode  = mode_q;
  assign snoop_count = count_q;

  // R10
  underflow_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> (tx_pop == 2'd0) && (rx_push == 2'd0));

  // R10
  underflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> $stable(snoop_mode) && $stable(snoop_count));

  // R8
  stripe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_mode == 2'd3) && dual_en && xfer_step && cs_active && !underflow
      |-> (tx_pop == 2'd2) && (rx_push == 2'd2));

  // R7
  shared_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_active && xfer_step && (snoop_mode != 2'd3)
      |-> (bus1_tx == tx_head0) && (tx_pop <= 2'd1));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_active && !xfer_step |-> (tx_pop == 2'd0) ##1 $stable(snoop_mode));

endmodule

// File: tb/dual_flash_snoop_tb.sv
module dual_flash_snoop_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_active = 1'b0, dual_en = 1'b1, xfer_step = 1'b0;
  logic [1:0] tx_avail = 2'd0;
  logic [7:0] tx_head0 = 8'h00, tx_head1 = 8'h00, bus0_rx = 8'h00, bus1_rx = 8'h00;
  logic [7:0] bus0_tx, bus1_tx, rx_byte0, rx_byte1;
  logic [1:0] tx_pop, rx_push, snoop_mode;
  logic [2:0] snoop_count;
  logic       underflow;

  int checks = 0;
  int fails  = 0;
  int exp_mode = 0;
  int exp_cnt  = 0;

  always #10 clk = ~clk;

  dual_flash_snoop u_dut (
    .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .dual_en(dual_en),
    .xfer_step(xfer_step), .tx_avail(tx_avail), .tx_head0(tx_head0),
    .tx_head1(tx_head1), .bus0_rx(bus0_rx), .bus1_rx(bus1_rx),
    .bus0_tx(bus0_tx), .bus1_tx(bus1_tx), .tx_pop(tx_pop), .rx_push(rx_push),
    .rx_byte0(rx_byte0), .rx_byte1(rx_byte1), .underflow(underflow),
    .snoop_mode(snoop_mode), .snoop_count(snoop_count)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int class_len(input logic [7:0] op);
    if (op inside {8'hEB}) return 6;
    if (op inside {8'h0B, 8'h3B, 8'h6B, 8'hBB}) return 4;
    if (op inside {8'h03, 8'h02, 8'hA2, 8'h32}) return 3;
    return 0;
  endfunction

  function automatic string class_tag(input int n);
    if (n == 3) return "R2";
    if (n == 4) return "R3";
    if (n == 6) return "R4";
    return "R5";
  endfunction

  // One cycle of stimulus: drive after negedge, check outputs, check state after posedge.
  task automatic xchg(input logic [7:0] h0, input logic [7:0] h1, input logic [1:0] avail,
                      input bit step, input bit cs, input bit dual);
    int need, pop_e;
    bit act, shrt, two;
    string ptag, stag;
    @(negedge clk);
    tx_head0 = h0; tx_head1 = h1; tx_avail = avail;
    xfer_step = step; cs_active = cs; dual_en = dual;
    bus0_rx = ~h0; bus1_rx = h1 ^ 8'h5A;
    two  = dual && (exp_mode == 3);
    need = two ? 2 : 1;
    act  = step && cs;
    shrt = act && (int'(avail) < need);
    pop_e = (act && !shrt) ? need : 0;
    if (!cs) ptag = "R11";
    else if (!step) ptag = "R12";
    else if (shrt) ptag = "R10";
    else if (two) ptag = "R8";
    else if (exp_mode == 3) ptag = "R9";
    else ptag = "R7";
    #3;
    check(tx_pop == pop_e[1:0], ptag, "tx_pop", tx_pop, pop_e);
    check(rx_push == pop_e[1:0], ptag, "rx_push", rx_push, pop_e);
    check(underflow == shrt, ptag, "underflow", underflow, shrt);
    check(bus0_tx == h0, ptag, "bus0_tx", bus0_tx, h0);
    check(bus1_tx == (two ? h1 : h0), ptag, "bus1_tx", bus1_tx, two ? h1 : h0);
    check(rx_byte0 == ~h0, ptag, "rx_byte0", rx_byte0, ~h0);
    if (two) check(rx_byte1 == (h1 ^ 8'h5A), ptag, "rx_byte1", rx_byte1, h1 ^ 8'h5A);
    stag = ptag;
    if (!cs) begin
      exp_mode = 0; exp_cnt = 0;
    end else if (act && !shrt) begin
      if (exp_mode == 0) begin
        exp_cnt  = class_len(h0);
        stag     = class_tag(exp_cnt);
        exp_mode = (exp_cnt == 0) ? 1 : 2;
      end else if (exp_mode == 2) begin
        stag = "R6";
        exp_cnt--;
        if (exp_cnt == 0) exp_mode = 3;
      end else if (exp_mode == 1) stag = "R5";
    end
    @(posedge clk);
    #3;
    check(snoop_mode == exp_mode[1:0], stag, "snoop_mode", snoop_mode, exp_mode);
    check(snoop_count == exp_cnt[2:0], stag, "snoop_count", snoop_count, exp_cnt);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #35;
    // R1: reset state
    check(snoop_mode == 2'd0, "R1", "snoop_mode", snoop_mode, 0);
    check(snoop_count == 3'd0, "R1", "snoop_count", snoop_count, 0);
    rst_n = 1'b1;

    // R2 R3 R4 R5 R6 R7 R8: sweep of every opcode through header and data
    for (int op = 0; op < 256; op++) begin
      int n;
      xchg(8'h00, 8'h00, 2'd3, 1'b1, 1'b0, 1'b1);
      xchg(op[7:0], 8'h11, 2'd3, 1'b1, 1'b1, 1'b1);
      n = class_len(op[7:0]);
      for (int k = 0; k < n + 2; k++)
        xchg(8'(op + k * 7), 8'(op ^ (k * 13)), 2'd3, 1'b1, 1'b1, 1'b1);
      if (n == 0)
        for (int k = 0; k < 3; k++) xchg(8'(k + 1), 8'hC3, 2'd3, 1'b1, 1'b1, 1'b1);
    end

    // R9: dual mode off never splits data
    xchg(8'h00, 8'h00, 2'd3, 1'b0, 1'b0, 1'b0);
    xchg(8'h03, 8'h44, 2'd3, 1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 5; k++) xchg(8'(8'h20 + k), 8'h99, 2'd3, 1'b1, 1'b1, 1'b0);

    // R10: underflow on opcode byte and on an interleaved exchange
    xchg(8'h00, 8'h00, 2'd3, 1'b0, 1'b0, 1'b1);
    xchg(8'h0B, 8'h00, 2'd0, 1'b1, 1'b1, 1'b1);
    xchg(8'h0B, 8'h00, 2'd1, 1'b1, 1'b1, 1'b1);
    xchg(8'hA0, 8'h00, 2'd0, 1'b1, 1'b1, 1'b1);
    for (int k = 0; k < 4; k++) xchg(8'(8'h30 + k), 8'h00, 2'd1, 1'b1, 1'b1, 1'b1);
    xchg(8'h55, 8'h66, 2'd1, 1'b1, 1'b1, 1'b1);
    xchg(8'h55, 8'h66, 2'd2, 1'b1, 1'b1, 1'b1);

    // R12: no step holds state
    xchg(8'h77, 8'h88, 2'd3, 1'b0, 1'b1, 1'b1);

    // R11: chip select drop mid-header, step ignored
    xchg(8'h00, 8'h00, 2'd3, 1'b1, 1'b0, 1'b1);
    xchg(8'hEB, 8'h00, 2'd3, 1'b1, 1'b1, 1'b1);
    xchg(8'h01, 8'h00, 2'd3, 1'b1, 1'b1, 1'b1);
    xchg(8'h02, 8'h00, 2'd3, 1'b1, 1'b0, 1'b1);
    xchg(8'h6B, 8'h00, 2'd3, 1'b1, 1'b1, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule